// File: doc/BRIEF.md
# Timer-Triggered ADC Scan Sequencer

This block decides what a shared analog-to-digital converter samples and in which order. Software sets up a control word and a list of up to four regular channels. After that, each event on the selected trigger line starts one burst that walks the list. Every regular result lands in a single data register, and a data request is raised so a DMA engine can move the value into memory before the next result arrives. Because the trigger is a hardware timer event, the sample timing does not depend on software.

Software can also post a one-shot injected request for one to four extra channels. A request posted while a regular burst is running waits until the last regular channel of that burst is done. A request posted while the block is idle starts at once. Injected results go to their own per-rank outputs. They never disturb the regular data register or the request line. A sticky flag reports when the last injected rank has finished.

The converter is driven through a simple handshake. The block pulses a start with a channel number, then waits for a done strobe that carries a 12-bit result.

Top module: `adc_scan_seq`

## Requirements
- R1: With the converter-on bit (control bit 0) clear, no trigger starts a conversion and no pending injected request is started.
- R2: A burst starts only when the trigger-enable bit (control bit 3) is set and the trigger line chosen by the 3-bit select field at control bits 19:17 is high for a cycle. The other trigger lines have no effect.
- R3: The regular sequence register holds channel numbers in 5-bit fields at bits 4:0, 9:5, 14:10 and 19:15. These are converted in that order. Bits 21:20 hold the sequence length minus one.
- R4: With the scan bit (control bit 1) clear, a trigger converts only the channel in bits 4:0.
- R5: When the DMA-enable bit (control bit 2) is set, each regular result is written to `dout` and `dreq` is raised. `dreq` stays high until a `dack` pulse.
- R6: With DMA-enable clear, regular results still update `dout`, but `dreq` stays low.
- R7: A trigger that arrives while a sequence is in progress is ignored and sets `ovr`. Writing 1 to bit 1 at register address 3 clears `ovr`.
- R8: When a regular result completes while `dreq` is still unacknowledged, `ovr` is set, `dout` takes the new result and `dreq` stays high.
- R9: An injected request is posted by writing register address 2 with bit 22 set. Its channels sit in the same field layout as R3, with the length at bits 21:20. It starts only after the last regular channel of a running burst, and it runs exactly once.
- R10: Injected results of rank k appear on `inj_data[12k+11:12k]`. They never change `dout` and never raise `dreq`.
- R11: `inj_done` is set when the last injected rank completes. Writing 1 to bit 0 at register address 3 clears it.
- R12: Each conversion issues a single one-cycle `cv_start` with its channel on `cv_chan`. The next start comes only after `cv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| wr_en | input | 1 | register write strobe |
| wr_addr | input | 2 | 0 control, 1 regular sequence, 2 injected sequence, 3 status clear |
| wr_data | input | 32 | register write data |
| trig_evt | input | 8 | trigger event lines |
| cv_start | output | 1 | converter start pulse |
| cv_chan | output | 5 | channel to convert |
| cv_done | input | 1 | converter result strobe |
| cv_result | input | 12 | converter result |
| dreq | output | 1 | data request |
| dack | input | 1 | data acknowledge pulse |
| dout | output | 12 | regular data register |
| inj_data | output | 48 | injected results, rank 0 in the low bits |
| ovr | output | 1 | overrun flag |
| inj_done | output | 1 | injected sequence complete flag |

## Verification
The regular path is driven with a full four-channel list that has scattered channel numbers, a two-channel list, and a single channel with scan off. These runs separate length decoding from field order. The trigger is tried with the converter off, with trigger enable off, on an unselected line and on the selected line, so each gate is seen on its own. Overrun is provoked in two ways: a second trigger during a burst, and a DMA side that does not acknowledge. Injected requests are posted both in the middle of a burst and while idle. This shows that the request is deferred, that it runs only once, and that regular data and requests stay untouched.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int CH_W  = 5,
  parameter int RES_W = 12,
  parameter int RANKS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [1:0]             wr_addr,
  input  logic [31:0]            wr_data,
  input  logic [7:0]             trig_evt,
  output logic                   cv_start,
  output logic [CH_W-1:0]        cv_chan,
  input  logic                   cv_done,
  input  logic [RES_W-1:0]       cv_result,
  output logic                   dreq,
  input  logic                   dack,
  output logic [RES_W-1:0]       dout,
  output logic [RANKS*RES_W-1:0] inj_data,
  output logic                   ovr,
  output logic                   inj_done
);
  localparam int RK_W    = $clog2(RANKS);
  localparam int LEN_LSB = RANKS * CH_W;
  localparam int SEQ_W   = LEN_LSB + RK_W;
  localparam int GO_BIT  = SEQ_W;

  typedef enum logic [1:0] {S_IDLE, S_START, S_WAIT} st_t;

  st_t             state;
  logic            conv_on, scan_en, dma_en, trig_en;
  logic [2:0]      trig_sel;
  logic [SEQ_W-1:0] seq_cfg, inj_cfg;
  logic            inj_pend, inj_mode;
  logic [RK_W-1:0] rank;

  wire             trig_hit = conv_on & trig_en & trig_evt[trig_sel];
  wire [RK_W-1:0]  reg_last = scan_en ? seq_cfg[LEN_LSB +: RK_W] : '0;
  wire [RK_W-1:0]  inj_last = inj_cfg[LEN_LSB +: RK_W];
  wire [RK_W-1:0]  last     = inj_mode ? inj_last : reg_last;
  wire             conv_end = (state == S_WAIT) && cv_done;
  wire             reg_end  = conv_end && !inj_mode;

  wire unused_bits = ^{wr_data[31:GO_BIT+1], wr_data[16:4]};

  assign cv_start = (state == S_START);
  assign cv_chan  = inj_mode ? inj_cfg[rank*CH_W +: CH_W] : seq_cfg[rank*CH_W +: CH_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      conv_on  <= 1'b0;
      scan_en  <= 1'b0;
      dma_en   <= 1'b0;
      trig_en  <= 1'b0;
      trig_sel <= '0;
      seq_cfg  <= '0;
      inj_cfg  <= '0;
      inj_pend <= 1'b0;
      inj_mode <= 1'b0;
      rank     <= '0;
      dreq     <= 1'b0;
      dout     <= '0;
      inj_data <= '0;
      ovr      <= 1'b0;
      inj_done <= 1'b0;
    end else begin
      if (wr_en && wr_addr == 2'd3) begin
        if (wr_data[0]) inj_done <= 1'b0;
        if (wr_data[1]) ovr <= 1'b0;
      end
      if (wr_en && wr_addr == 2'd0) begin
        conv_on  <= wr_data[0];
        scan_en  <= wr_data[1];
        dma_en   <= wr_data[2];
        trig_en  <= wr_data[3];
        trig_sel <= wr_data[19:17];
      end
      if (wr_en && wr_addr == 2'd1) seq_cfg <= wr_data[SEQ_W-1:0];

      if (dack) dreq <= 1'b0;
      if (trig_hit && state != S_IDLE) ovr <= 1'b1;

      if (reg_end) begin
        dout <= cv_result;
        if (dma_en) begin
          if (dreq && !dack) ovr <= 1'b1;
          dreq <= 1'b1;
        end
      end
      if (conv_end && inj_mode) inj_data[rank*RES_W +: RES_W] <= cv_result;

      case (state)
        S_IDLE: begin
          if (trig_hit) begin
            inj_mode <= 1'b0;
            rank     <= '0;
            state    <= S_START;
          end else if (inj_pend && conv_on) begin
            inj_mode <= 1'b1;
            inj_pend <= 1'b0;
            rank     <= '0;
            state    <= S_START;
          end
        end
        S_START: state <= S_WAIT;
        S_WAIT: begin
          if (cv_done) begin
            if (rank == last) begin
              if (inj_mode) inj_done <= 1'b1;
              if (!inj_mode && inj_pend) begin
                inj_mode <= 1'b1;
                inj_pend <= 1'b0;
                rank     <= '0;
                state    <= S_START;
              end else begin
                state <= S_IDLE;
              end
            end else begin
              rank  <= rank + RK_W'(1);
              state <= S_START;
            end
          end
        end
        default: state <= S_IDLE;
      endcase

      if (wr_en && wr_addr == 2'd2) begin
        inj_cfg <= wr_data[SEQ_W-1:0];
        if (wr_data[GO_BIT]) inj_pend <= 1'b1;
      end
    end
  end

  // R12: start is a single-cycle pulse
  a_r12_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cv_start |=> !cv_start);

  // R1: an idle sequencer with the converter off never starts
  a_r1_off_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !conv_on) |=> !cv_start);

  // R5: a request is only dropped by an acknowledge
  a_r5_dreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && !dack) |=> dreq);

  // R7: a trigger while busy flags an overrun
  a_r7_busy_trig: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_hit && state != S_IDLE) |=> ovr);

  // R8: result over an unacknowledged request flags an overrun
  a_r8_unacked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_end && dma_en && dreq && !dack) |=> (ovr && dreq));

  // R10: injected results leave the regular path alone
  a_r10_inj_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_end && inj_mode) |=> ($stable(dout) && !$rose(dreq)));

  // R11: last injected rank sets the complete flag
  a_r11_inj_done: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_end && inj_mode && rank == inj_last) |=> inj_done);
endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  trig_evt = '0;
  logic        cv_start;
  logic [4:0]  cv_chan;
  logic        cv_done = 1'b0;
  logic [11:0] cv_result = '0;
  logic        dreq;
  logic        dack = 1'b0;
  logic [11:0] dout;
  logic [47:0] inj_data;
  logic        ovr, inj_done;

  int checks = 0, fails = 0;
  logic ack_en = 1'b1;

  always #5 clk = ~clk;

  adc_scan_seq i_adc_scan_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_evt(trig_evt), .cv_start(cv_start), .cv_chan(cv_chan), .cv_done(cv_done),
    .cv_result(cv_result), .dreq(dreq), .dack(dack), .dout(dout),
    .inj_data(inj_data), .ovr(ovr), .inj_done(inj_done));

  function automatic logic [11:0] fres(input int ch);
    return 12'(ch * 37 + 5);
  endfunction

  // converter model
  int cnt = 0;
  logic [4:0] ch_l = '0;
  always @(posedge clk) begin
    cv_done <= 1'b0;
    if (cnt != 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        cv_done   <= 1'b1;
        cv_result <= fres(int'(ch_l));
      end
    end else if (cv_start) begin
      ch_l <= cv_chan;
      cnt  <= 3;
    end
  end

  // start log and DMA model
  int chlog[256];
  int nch = 0;
  int dlog[256];
  int nd = 0;
  always @(posedge clk) begin
    if (cv_start) begin
      chlog[nch % 256] <= int'(cv_chan);
      nch <= nch + 1;
    end
  end
  always @(posedge clk) begin
    dack <= 1'b0;
    if (dreq && ack_en && !dack) begin
      dlog[nd % 256] <= int'(dout);
      nd   <= nd + 1;
      dack <= 1'b1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  function automatic logic [31:0] ctl(input bit on, input bit scan, input bit dma,
                                      input bit ten, input int sel);
    return 32'(on) | (32'(scan) << 1) | (32'(dma) << 2) | (32'(ten) << 3) | (32'(sel) << 17);
  endfunction

  function automatic logic [31:0] seqw(input int c0, input int c1, input int c2,
                                       input int c3, input int len);
    return 32'(c0) | (32'(c1) << 5) | (32'(c2) << 10) | (32'(c3) << 15) | (32'(len) << 20);
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int line);
    @(negedge clk);
    trig_evt[line] = 1'b1;
    @(negedge clk);
    trig_evt = '0;
  endtask

  task automatic settle();
    repeat (80) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R5 reset dreq", int'(dreq), 0);
    check("R5 reset dout", int'(dout), 0);
    check("R7 reset ovr", int'(ovr), 0);
    check("R11 reset inj_done", int'(inj_done), 0);
    check("R12 reset start", int'(cv_start), 0);
  endtask

  task automatic t_gating();
    int b;
    wr(1, seqw(6, 7, 8, 9, 3));
    wr(0, ctl(0, 0, 1, 1, 0));
    b = nch; pulse(0); settle();
    check("R1 converter off blocks trigger", nch - b, 0);
    wr(0, ctl(1, 0, 1, 0, 0));
    b = nch; pulse(0); settle();
    check("R2 trigger enable off", nch - b, 0);
    wr(0, ctl(1, 0, 1, 1, 2));
    b = nch; pulse(5); settle();
    check("R2 unselected line", nch - b, 0);
    b = nch; pulse(2); settle();
    check("R2 selected line", nch - b, 1);
    check("R4 scan off first channel only", chlog[b], 6);
    check("R5 dout after single", int'(dout), int'(fres(6)));
  endtask

  task automatic t_scan4();
    int b, bd;
    int exp[4] = '{3, 17, 9, 30};
    wr(1, seqw(3, 17, 9, 30, 3));
    wr(0, ctl(1, 1, 1, 1, 0));
    b = nch; bd = nd; pulse(0); settle();
    check("R12 one start per channel", nch - b, 4);
    for (int i = 0; i < 4; i++) begin
      check("R3 channel order", chlog[b + i], exp[i]);
      check("R5 dma data", dlog[bd + i], int'(fres(exp[i])));
    end
    check("R5 request count", nd - bd, 4);
    check("R5 dreq released", int'(dreq), 0);
    check("R7 no overrun", int'(ovr), 0);
  endtask

  task automatic t_len2();
    int b;
    wr(1, seqw(11, 12, 13, 14, 1));
    b = nch; pulse(0); settle();
    check("R3 length two", nch - b, 2);
    check("R3 second channel", chlog[b + 1], 12);
  endtask

  task automatic t_nodma();
    int bd;
    wr(1, seqw(3, 17, 9, 30, 3));
    wr(0, ctl(1, 1, 0, 1, 0));
    bd = nd; pulse(0); settle();
    check("R6 no requests", nd - bd, 0);
    check("R6 dreq low", int'(dreq), 0);
    check("R6 dout last result", int'(dout), int'(fres(30)));
  endtask

  task automatic t_busy_trig();
    int b;
    wr(0, ctl(1, 1, 1, 1, 0));
    b = nch; pulse(0);
    repeat (4) @(negedge clk);
    pulse(0); settle();
    check("R7 second trigger ignored", nch - b, 4);
    check("R7 overrun set", int'(ovr), 1);
    wr(3, 32'h2);
    check("R7 overrun cleared", int'(ovr), 0);
  endtask

  task automatic t_unacked();
    int bd;
    ack_en = 1'b0;
    wr(1, seqw(3, 17, 0, 0, 1));
    bd = nd; pulse(0); settle();
    check("R8 overrun on pending request", int'(ovr), 1);
    check("R8 dout overwritten", int'(dout), int'(fres(17)));
    check("R8 dreq held", int'(dreq), 1);
    ack_en = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 single transfer after ack", nd - bd, 1);
    check("R8 transferred value", dlog[bd], int'(fres(17)));
    check("R5 dreq drops on ack", int'(dreq), 0);
    wr(3, 32'h2);
  endtask

  task automatic t_inj_defer();
    int b, bd;
    wr(1, seqw(3, 17, 9, 30, 3));
    b = nch; bd = nd; pulse(0);
    repeat (3) @(negedge clk);
    wr(2, seqw(20, 21, 0, 0, 1) | 32'h40_0000);
    settle();
    check("R9 total conversions", nch - b, 6);
    check("R9 regular first", chlog[b + 3], 30);
    check("R9 injected rank0 after burst", chlog[b + 4], 20);
    check("R9 injected rank1", chlog[b + 5], 21);
    check("R10 rank0 result", int'(inj_data[11:0]), int'(fres(20)));
    check("R10 rank1 result", int'(inj_data[23:12]), int'(fres(21)));
    check("R10 no extra requests", nd - bd, 4);
    check("R10 dout keeps regular", int'(dout), int'(fres(30)));
    check("R11 complete set", int'(inj_done), 1);
    wr(3, 32'h1);
    check("R11 complete cleared", int'(inj_done), 0);
  endtask

  task automatic t_inj_idle();
    int b;
    b = nch;
    wr(2, seqw(1, 2, 3, 4, 3) | 32'h40_0000);
    settle();
    check("R9 idle request runs", nch - b, 4);
    settle();
    check("R9 runs only once", nch - b, 4);
    for (int i = 0; i < 4; i++)
      check("R10 rank result", int'(inj_data[i*12 +: 12]), int'(fres(i + 1)));
    check("R11 complete set idle", int'(inj_done), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gating();
    t_scan4();
    t_len2();
    t_nodma();
    t_busy_trig();
    t_unacked();
    t_inj_defer();
    t_inj_idle();
    summary();
  end
endmodule